// File: doc/BRIEF.md
# Legacy I/O Header Register Decoder

This block is the compatibility register window that a transitional paravirtual device shows in its first I/O region. A small fixed header of byte-addressed registers sits at the bottom of the window. Everything above the header belongs to the device-specific configuration. The header is decoded locally, and the device-specific region is handed on through a forwarding sub-port, with the offset rebased to zero.

The layout changes at run time. While `msixEn` is low, the header ends at byte 20 and the device region starts there. While it is high, two 16-bit interrupt vector registers (configuration and per-queue) take bytes 20..23, and the device region moves to byte 24. Driving `msixEn` low again moves it back. Only the low 32 feature bits can be reached through this window. The 64-bit acknowledged-feature output therefore always reports the upper half as not acknowledged.

Each queue keeps a page frame number. The ring base it presents is that number shifted left by 12 bits. Writing a queue index to the notify register produces a one-cycle kick for that queue.

Top module: `legacy_io_hdr`

## Requirements
- R1: Header registers sit at fixed byte offsets with natural widths (size code 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes): device features 0 (4 B), driver features 4 (4 B), queue page frame 8 (4 B), queue size 12 (2 B), queue select 14 (2 B), queue notify 16 (2 B), device status 18 (1 B), interrupt status 19 (1 B), config vector 20 (2 B), queue vector 22 (2 B); read data is right-aligned in `rdData`.
- R2: A read at offset 0 returns `devFeatures`. Offset 4 is read/write, and its value appears as `drvFeatures[31:0]`. `drvFeatures[63:32]` is always zero.
- R3: Queue select picks the queue. The page frame register (reset 0) and the queue vector are stored per queue. Queue size reads `MAX_QSIZE` for a selection below `NUM_Q`. With a selection at or above `NUM_Q`, per-queue reads return 0 and per-queue writes are dropped.
- R4: A header access whose size code differs from the natural width, or whose offset is not a field start, is ignored on write and reads as 0.
- R5: The result of a read appears in `rdData`, with `rdValid` high, in the cycle after the one in which `rdEn` was sampled.
- R6: With `msixEn` low, the device region begins at byte 20. With `msixEn` high, it begins at byte 24, and bytes 20 and 22 hold the config and queue vectors, both reset to 16'hFFFF.
- R7: In the device region, `devRd` or `devWr` is asserted in the same cycle as the access. `devAddr` carries the offset minus the region base, any size code is passed on, and read data is taken from `devRdData`.
- R8: A 2-byte write to offset 16 with a value below `NUM_Q` raises `kickValid` for exactly the next cycle, with `kickQueue` equal to that value. Larger values give no kick.
- R9: Bits of `isrSet` collect in an 8-bit pending register. With `msixEn` low, a read at offset 19 returns the pending bits and clears them. With `msixEn` high, the same read returns 0 and clears nothing.
- R10: Device status at offset 18 is an 8-bit read/write register that resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rdEn | input | 1 | Read request this cycle |
| wrEn | input | 1 | Write request this cycle |
| addr | input | ADDR_W | Byte offset in the window |
| size | input | 2 | Access size code |
| wrData | input | 32 | Write data, right-aligned |
| rdData | output | 32 | Read data, one cycle after the request |
| rdValid | output | 1 | Read data valid |
| msixEn | input | 1 | Message-signalled interrupts enabled |
| devFeatures | input | 32 | Feature bits offered by the device |
| drvFeatures | output | 64 | Feature bits acknowledged by the driver |
| isrSet | input | 8 | Interrupt status bits to set |
| ringBase | output | NUM_Q*(32+PAGE_SHIFT) | Ring base address for each queue |
| kickValid | output | 1 | Queue notification pulse |
| kickQueue | output | QIDX_W | Index of the notified queue |
| devRd | output | 1 | Read forwarded to the device region |
| devWr | output | 1 | Write forwarded to the device region |
| devAddr | output | ADDR_W | Offset within the device region |
| devSize | output | 2 | Forwarded size code |
| devWrData | output | 32 | Forwarded write data |
| devRdData | input | 32 | Read data from the device region |

## Verification
The bench reads the same offsets, 20 and 24, with `msixEn` low and then high. A decoder that fixes the device base would return a vector where device data is expected, or the reverse, and would forward an offset that is off by four. It also tries wrong-width and unaligned header accesses. A decoder that ignores the size code would corrupt driver features on a byte write.

Queue selections above the queue count are exercised too; an unguarded index would alias onto a real queue. Interrupt-status reads are tested for read-then-clear, and for being inert while MSI-X is on. A design that clears on every read would lose pending bits. Notify values are tested for a single-cycle kick, and out-of-range notify values for no kick at all.

// File: rtl/legio_pkg.sv
package legio_pkg;

  // Header byte offsets (behavioural: software decodes these)
  localparam int OFS_DEVFEAT = 0;
  localparam int OFS_DRVFEAT = 4;
  localparam int OFS_QPFN    = 8;
  localparam int OFS_QSIZE   = 12;
  localparam int OFS_QSEL    = 14;
  localparam int OFS_NOTIFY  = 16;
  localparam int OFS_STATUS  = 18;
  localparam int OFS_ISR     = 19;
  localparam int OFS_CFGVEC  = 20;
  localparam int OFS_QVEC    = 22;
  localparam int BASE_PLAIN  = 20;
  localparam int BASE_MSIX   = 24;

  localparam logic [1:0] SZ_B = 2'd0;
  localparam logic [1:0] SZ_H = 2'd1;
  localparam logic [1:0] SZ_W = 2'd2;

  localparam logic [15:0] NO_VECTOR = 16'hFFFF;

  typedef enum logic [3:0] {
    F_NONE, F_DEVFEAT, F_DRVFEAT, F_QPFN, F_QSIZE, F_QSEL,
    F_NOTIFY, F_STATUS, F_ISR, F_CFGVEC, F_QVEC, F_DEV
  } field_e;

  typedef struct packed {
    field_e field;
    logic   rdStb;
    logic   wrStb;
  } strobe_t;

endpackage

// File: rtl/legio_ctrl.sv
module legio_ctrl
  import legio_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic              msixEn,
  output strobe_t           stb,
  output logic [ADDR_W-1:0] devOffset
);

  logic [ADDR_W-1:0] devBase;
  field_e            hdrField;
  logic [1:0]        wantSize;

  assign devBase = msixEn ? ADDR_W'(BASE_MSIX) : ADDR_W'(BASE_PLAIN);

  always_comb begin
    hdrField = F_NONE;
    wantSize = SZ_W;
    case (addr)
      ADDR_W'(OFS_DEVFEAT): begin hdrField = F_DEVFEAT; wantSize = SZ_W; end
      ADDR_W'(OFS_DRVFEAT): begin hdrField = F_DRVFEAT; wantSize = SZ_W; end
      ADDR_W'(OFS_QPFN):    begin hdrField = F_QPFN;    wantSize = SZ_W; end
      ADDR_W'(OFS_QSIZE):   begin hdrField = F_QSIZE;   wantSize = SZ_H; end
      ADDR_W'(OFS_QSEL):    begin hdrField = F_QSEL;    wantSize = SZ_H; end
      ADDR_W'(OFS_NOTIFY):  begin hdrField = F_NOTIFY;  wantSize = SZ_H; end
      ADDR_W'(OFS_STATUS):  begin hdrField = F_STATUS;  wantSize = SZ_B; end
      ADDR_W'(OFS_ISR):     begin hdrField = F_ISR;     wantSize = SZ_B; end
      ADDR_W'(OFS_CFGVEC):  begin hdrField = F_CFGVEC;  wantSize = SZ_H; end
      ADDR_W'(OFS_QVEC):    begin hdrField = F_QVEC;    wantSize = SZ_H; end
      default:              begin hdrField = F_NONE;    wantSize = SZ_W; end
    endcase
  end

  always_comb begin
    devOffset = '0;
    if (addr >= devBase) begin
      stb.field = F_DEV;
      devOffset = addr - devBase;
    end else if (size == wantSize) begin
      stb.field = hdrField;
    end else begin
      stb.field = F_NONE;
    end
    stb.rdStb = rdEn && (stb.field != F_NONE);
    stb.wrStb = wrEn && (stb.field != F_NONE);
  end

endmodule

// File: rtl/legio_dp.sv
module legio_dp
  import legio_pkg::*;
#(
  parameter int NUM_Q      = 4,
  parameter int MAX_QSIZE  = 256,
  parameter int PAGE_SHIFT = 12,
  parameter int QIDX_W     = 2,
  parameter int PA_W       = 44
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               stb,
  input  logic                  rdEn,
  input  logic                  msixEn,
  input  logic [31:0]           wrData,
  input  logic [31:0]           devFeatures,
  input  logic [7:0]            isrSet,
  input  logic [31:0]           devRdData,
  output logic [31:0]           rdData,
  output logic                  rdValid,
  output logic [63:0]           drvFeatures,
  output logic [NUM_Q*PA_W-1:0] ringBase,
  output logic                  kickValid,
  output logic [QIDX_W-1:0]     kickQueue
);

  logic [31:0] drvFeatLo;
  logic [15:0] qSel;
  logic [7:0]  devStatus;
  logic [7:0]  isrPend;
  logic [15:0] cfgVec;
  logic [31:0] qPfn [NUM_Q];
  logic [15:0] qVec [NUM_Q];

  logic              selValid;
  logic [QIDX_W-1:0] selIdx;
  logic              isrClr;
  logic [31:0]       rdNext;
  logic              notifyOk;

  assign selValid = qSel < 16'(NUM_Q);
  assign selIdx   = qSel[QIDX_W-1:0];
  assign isrClr   = stb.rdStb && (stb.field == F_ISR) && !msixEn;
  assign notifyOk = stb.wrStb && (stb.field == F_NOTIFY) && (wrData[15:0] < 16'(NUM_Q));

  // Scalar header registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      drvFeatLo <= '0;
      qSel      <= '0;
      devStatus <= '0;
      cfgVec    <= NO_VECTOR;
    end else if (stb.wrStb) begin
      case (stb.field)
        F_DRVFEAT: drvFeatLo <= wrData;
        F_QSEL:    qSel      <= wrData[15:0];
        F_STATUS:  devStatus <= wrData[7:0];
        F_CFGVEC:  cfgVec    <= wrData[15:0];
        default:   ;
      endcase
    end
  end

  // Per-queue state
  for (genvar gi = 0; gi < NUM_Q; gi++) begin : g_queue
    logic hitMe;
    assign hitMe = stb.wrStb && selValid && (selIdx == QIDX_W'(gi));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        qPfn[gi] <= '0;
        qVec[gi] <= NO_VECTOR;
      end else if (hitMe) begin
        if (stb.field == F_QPFN) qPfn[gi] <= wrData;
        if (stb.field == F_QVEC) qVec[gi] <= wrData[15:0];
      end
    end

    assign ringBase[gi*PA_W +: PA_W] = {qPfn[gi], {PAGE_SHIFT{1'b0}}};
  end

  // Interrupt status: sticky set, cleared by a read when vectors are off
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) isrPend <= '0;
    else       isrPend <= (isrClr ? 8'h00 : isrPend) | isrSet;
  end

  // Read mux
  always_comb begin
    rdNext = '0;
    if (stb.rdStb) begin
      case (stb.field)
        F_DEVFEAT: rdNext = devFeatures;
        F_DRVFEAT: rdNext = drvFeatLo;
        F_QPFN:    rdNext = selValid ? qPfn[selIdx] : 32'h0;
        F_QSIZE:   rdNext = selValid ? 32'(MAX_QSIZE) : 32'h0;
        F_QSEL:    rdNext = {16'h0, qSel};
        F_STATUS:  rdNext = {24'h0, devStatus};
        F_ISR:     rdNext = msixEn ? 32'h0 : {24'h0, isrPend};
        F_CFGVEC:  rdNext = {16'h0, cfgVec};
        F_QVEC:    rdNext = selValid ? {16'h0, qVec[selIdx]} : 32'h0;
        F_DEV:     rdNext = devRdData;
        default:   rdNext = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData    <= '0;
      rdValid   <= 1'b0;
      kickValid <= 1'b0;
      kickQueue <= '0;
    end else begin
      rdData    <= rdNext;
      rdValid   <= rdEn;
      kickValid <= notifyOk;
      if (notifyOk) kickQueue <= wrData[QIDX_W-1:0];
    end
  end

  assign drvFeatures = {32'h0, drvFeatLo};

endmodule

// File: rtl/legacy_io_hdr.sv
module legacy_io_hdr
  import legio_pkg::*;
#(
  parameter int NUM_Q      = 4,
  parameter int ADDR_W     = 8,
  parameter int MAX_QSIZE  = 256,
  parameter int PAGE_SHIFT = 12,
  localparam int QIDX_W    = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
  localparam int PA_W      = 32 + PAGE_SHIFT
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  rdEn,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [1:0]            size,
  input  logic [31:0]           wrData,
  output logic [31:0]           rdData,
  output logic                  rdValid,
  input  logic                  msixEn,
  input  logic [31:0]           devFeatures,
  output logic [63:0]           drvFeatures,
  input  logic [7:0]            isrSet,
  output logic [NUM_Q*PA_W-1:0] ringBase,
  output logic                  kickValid,
  output logic [QIDX_W-1:0]     kickQueue,
  output logic                  devRd,
  output logic                  devWr,
  output logic [ADDR_W-1:0]     devAddr,
  output logic [1:0]            devSize,
  output logic [31:0]           devWrData,
  input  logic [31:0]           devRdData
);

  strobe_t stb;

  legio_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .rdEn(rdEn), .wrEn(wrEn), .addr(addr), .size(size),
    .msixEn(msixEn), .stb(stb), .devOffset(devAddr)
  );

  legio_dp #(
    .NUM_Q(NUM_Q), .MAX_QSIZE(MAX_QSIZE), .PAGE_SHIFT(PAGE_SHIFT),
    .QIDX_W(QIDX_W), .PA_W(PA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .rdEn(rdEn), .msixEn(msixEn),
    .wrData(wrData), .devFeatures(devFeatures), .isrSet(isrSet),
    .devRdData(devRdData), .rdData(rdData), .rdValid(rdValid),
    .drvFeatures(drvFeatures), .ringBase(ringBase),
    .kickValid(kickValid), .kickQueue(kickQueue)
  );

  assign devRd     = stb.rdStb && (stb.field == F_DEV);
  assign devWr     = stb.wrStb && (stb.field == F_DEV);
  assign devSize   = size;
  assign devWrData = wrData;

endmodule

// File: rtl/legio_checker.sv
module legio_checker #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdEn,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [1:0]        size,
  input logic              msixEn,
  input logic [31:0]       rdData,
  input logic              rdValid,
  input logic              kickValid,
  input logic              devRd,
  input logic              devWr
);

  logic [ADDR_W-1:0] hdrEnd;
  logic              sizeOk;

  assign hdrEnd = msixEn ? ADDR_W'(24) : ADDR_W'(20);

  always_comb begin
    case (addr)
      ADDR_W'(0), ADDR_W'(4), ADDR_W'(8): sizeOk = (size == 2'd2);
      ADDR_W'(12), ADDR_W'(14), ADDR_W'(16),
      ADDR_W'(20), ADDR_W'(22):           sizeOk = (size == 2'd1);
      ADDR_W'(18), ADDR_W'(19):           sizeOk = (size == 2'd0);
      default:                            sizeOk = 1'b0;
    endcase
  end

  a_r5_valid_after_read: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid);

  a_r5_no_stray_valid: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(rdEn));

  a_r8_kick_from_notify: assert property (@(posedge clk) disable iff (!rstN)
    kickValid |-> $past(wrEn && addr == ADDR_W'(16) && size == 2'd1));

  a_r7_forward_in_region: assert property (@(posedge clk) disable iff (!rstN)
    (devRd || devWr) |-> (addr >= hdrEnd));

  a_r4_bad_width_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr < hdrEnd && !sizeOk) |=> (rdData == 32'h0));

endmodule

bind legacy_io_hdr legio_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .rdEn(rdEn), .wrEn(wrEn), .addr(addr),
  .size(size), .msixEn(msixEn), .rdData(rdData), .rdValid(rdValid),
  .kickValid(kickValid), .devRd(devRd), .devWr(devWr)
);

// File: tb/sim_legacy_io_hdr.sv
module sim_legacy_io_hdr;

  localparam int NUM_Q = 4;
  localparam int PA_W  = 44;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rdEn = 1'b0, wrEn = 1'b0, msixEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [1:0]  size = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        rdValid;
  logic [31:0] devFeatures = 32'hCAFE0001;
  logic [63:0] drvFeatures;
  logic [7:0]  isrSet = '0;
  logic [NUM_Q*PA_W-1:0] ringBase;
  logic        kickValid;
  logic [1:0]  kickQueue;
  logic        devRd, devWr;
  logic [7:0]  devAddr;
  logic [1:0]  devSize;
  logic [31:0] devWrData;
  logic [31:0] devRdData;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  assign devRdData = 32'hD0000000 | 32'(devAddr);

  legacy_io_hdr u0 (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .wrEn(wrEn), .addr(addr),
    .size(size), .wrData(wrData), .rdData(rdData), .rdValid(rdValid),
    .msixEn(msixEn), .devFeatures(devFeatures), .drvFeatures(drvFeatures),
    .isrSet(isrSet), .ringBase(ringBase), .kickValid(kickValid),
    .kickQueue(kickQueue), .devRd(devRd), .devWr(devWr), .devAddr(devAddr),
    .devSize(devSize), .devWrData(devWrData), .devRdData(devRdData)
  );

  typedef struct packed {
    logic        msix;
    logic        wr;
    logic [7:0]  ofs;
    logic [1:0]  sz;
    logic [31:0] data;  // write data, or expected read data
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 8'd4,  2'd2, 32'h12345678, 8'd2},
    '{1'b0, 1'b0, 8'd4,  2'd2, 32'h12345678, 8'd2},  // R2 driver features
    '{1'b0, 1'b0, 8'd0,  2'd2, 32'hCAFE0001, 8'd2},  // R2 device features
    '{1'b0, 1'b1, 8'd14, 2'd1, 32'h00000002, 8'd3},
    '{1'b0, 1'b1, 8'd8,  2'd2, 32'h00000ABC, 8'd3},
    '{1'b0, 1'b0, 8'd8,  2'd2, 32'h00000ABC, 8'd3},  // R3 page frame
    '{1'b0, 1'b0, 8'd12, 2'd1, 32'h00000100, 8'd3},  // R3 queue size
    '{1'b0, 1'b1, 8'd14, 2'd1, 32'h00000007, 8'd3},
    '{1'b0, 1'b0, 8'd12, 2'd1, 32'h00000000, 8'd3},  // R3 bad select size
    '{1'b0, 1'b0, 8'd8,  2'd2, 32'h00000000, 8'd3},  // R3 bad select frame
    '{1'b0, 1'b1, 8'd4,  2'd0, 32'h000000FF, 8'd4},
    '{1'b0, 1'b0, 8'd4,  2'd2, 32'h12345678, 8'd4},  // R4 write dropped
    '{1'b0, 1'b0, 8'd4,  2'd1, 32'h00000000, 8'd4},  // R4 read zero
    '{1'b0, 1'b1, 8'd18, 2'd0, 32'h0000000F, 8'd10},
    '{1'b0, 1'b0, 8'd18, 2'd0, 32'h0000000F, 8'd10}, // R10 status
    '{1'b1, 1'b1, 8'd20, 2'd1, 32'h00000003, 8'd6},
    '{1'b1, 1'b0, 8'd20, 2'd1, 32'h00000003, 8'd6},  // R6 config vector
    '{1'b0, 1'b0, 8'd20, 2'd2, 32'hD0000000, 8'd6},  // R6 region at 20
    '{1'b1, 1'b0, 8'd24, 2'd0, 32'hD0000000, 8'd6},  // R6 region at 24
    '{1'b0, 1'b0, 8'd24, 2'd0, 32'hD0000004, 8'd7},  // R7 rebased offset
    '{1'b1, 1'b0, 8'd22, 2'd1, 32'h00000000, 8'd3},  // R3 vector, bad select
    '{1'b0, 1'b0, 8'd14, 2'd1, 32'h00000007, 8'd1}   // R1 select readback
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic m, input logic w, input logic [7:0] a,
                        input logic [1:0] s, input logic [31:0] d,
                        output logic [31:0] q);
    @(negedge clk);
    msixEn = m; rdEn = !w; wrEn = w; addr = a; size = s; wrData = d;
    @(negedge clk);
    rdEn = 1'b0; wrEn = 1'b0;
    q = rdData;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    logic [31:0] q;
    repeat (3) @(negedge clk);
    check("R5 reset rdValid", 64'(rdValid), 64'd0);
    check("R8 reset kickValid", 64'(kickValid), 64'd0);
    check("R2 reset drvFeatures", drvFeatures, 64'd0);
    rstN = 1'b1;
    access(1'b0, 1'b0, 8'd18, 2'd0, 32'h0, q);
    check("R10 status reset", 64'(q), 64'd0);
    check("R5 rdValid after read", 64'(rdValid), 64'd1);
    access(1'b1, 1'b0, 8'd20, 2'd1, 32'h0, q);
    check("R6 config vector reset", 64'(q), 64'h0000FFFF);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      access(VECS[i].msix, VECS[i].wr, VECS[i].ofs, VECS[i].sz, VECS[i].data, q);
      if (!VECS[i].wr)
        check($sformatf("R%0d vector %0d", VECS[i].req, i), 64'(q), 64'(VECS[i].data));
    end

    // R3 ring base of queue 2 from its page frame
    check("R3 ring base", 64'(ringBase[2*PA_W +: PA_W]), 64'h0000_0000_00AB_C000);

    // R2 upper feature half stays clear
    access(1'b0, 1'b1, 8'd4, 2'd2, 32'hFFFFFFFF, q);
    check("R2 upper features clear", drvFeatures, 64'h0000_0000_FFFF_FFFF);

    // R7 forwarding of a device write
    @(negedge clk);
    msixEn = 1'b0; wrEn = 1'b1; addr = 8'd21; size = 2'd0; wrData = 32'h5A;
    #1;
    check("R7 devWr asserted", 64'(devWr), 64'd1);
    check("R7 devAddr rebased", 64'(devAddr), 64'd1);
    check("R7 devWrData", 64'(devWrData), 64'h5A);
    msixEn = 1'b1;
    #1;
    check("R6 no forward below 24", 64'(devWr), 64'd0);
    @(negedge clk);
    wrEn = 1'b0;

    // R8 notify kicks
    access(1'b0, 1'b1, 8'd16, 2'd1, 32'd3, q);
    check("R8 kick pulse", 64'(kickValid), 64'd1);
    check("R8 kick queue", 64'(kickQueue), 64'd3);
    @(negedge clk);
    check("R8 kick one cycle", 64'(kickValid), 64'd0);
    access(1'b0, 1'b1, 8'd16, 2'd1, 32'd9, q);
    check("R8 no kick out of range", 64'(kickValid), 64'd0);

    // R9 interrupt status
    @(negedge clk); isrSet = 8'h05;
    @(negedge clk); isrSet = 8'h00;
    access(1'b0, 1'b0, 8'd19, 2'd0, 32'h0, q);
    check("R9 isr read", 64'(q), 64'h05);
    access(1'b0, 1'b0, 8'd19, 2'd0, 32'h0, q);
    check("R9 isr cleared", 64'(q), 64'h00);
    @(negedge clk); isrSet = 8'h02;
    @(negedge clk); isrSet = 8'h00;
    access(1'b1, 1'b0, 8'd19, 2'd0, 32'h0, q);
    check("R9 isr unused with vectors", 64'(q), 64'h00);
    access(1'b0, 1'b0, 8'd19, 2'd0, 32'h0, q);
    check("R9 isr not cleared with vectors", 64'(q), 64'h02);

    finished = 1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

endmodule